// File: doc/BRIEF.md
# Programmable Logic Slice

This block models one cell of a programmable logic fabric. It has two halves, lower and upper. Each half owns a four-input lookup table whose sixteen configuration bits can realise any Boolean function of its inputs. Around the tables sit a two-stage ripple carry path with sum gates, a multiplexer that joins the two table outputs into a five-input function, two bypass inputs that skip the tables, and one flip-flop per half with synchronous set and reset.

Every routing choice and every control polarity comes from static configuration inputs. These are held constant while the slice runs. A tile of such slices, wired to a configuration store, forms the logic array. This block is a single cell. Serial loading of the configuration and any use of the tables as memory are left to the parent.

Top module: `logic_slice`

## Requirements
- R1: With `x_sel`=0, `x` equals `lut_f_cfg[f_in]`, where `f_in` is read as an unsigned index with bit 3 as its MSB.
- R2: With `y_sel`=0, `y` equals `lut_g_cfg[g_in]`, indexed the same way.
- R3: With `x_sel`=1, `x` is the lower table output XOR `cin`. With `y_sel`=1, `y` is the upper table output XOR the carry passed between the halves.
- R4: The carry between the halves is `cin` when the lower table output is 1, and the effective BX otherwise. `cout` is that inner carry when the upper table output is 1, and the effective BY otherwise.
- R5: With `x_sel`=2, `x` is the upper table output when the effective BX is 1, and the lower table output when it is 0.
- R6: `bxout` and `byout` carry the effective BX and BY. Effective means the raw input XOR its `inv_bx`/`inv_by` bit.
- R7: When the effective CE is high and neither SR nor REV is active, each flip-flop loads on the active edge. `xq` loads the X line when `dx_sel`=0 and the effective BX when `dx_sel`=1. `yq` does the same with Y and BY through `dy_sel`.
- R8: While the effective CE is low and neither SR nor REV is active, `xq` and `yq` keep their value.
- R9: An active effective SR loads `ffx_init` into `xq` and `ffy_init` into `yq` on the active edge, whatever the value of CE.
- R10: When `rev_en`=1 and the effective BY is 1, both flip-flops load the inverse of their init value on the active edge, whatever the value of CE. SR takes priority over REV.
- R11: `inv_ce` and `inv_sr` invert CE and SR. With `inv_clk`=1 the flip-flops capture on the falling edge of `clk` and ignore its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock before polarity is applied |
| ce | input | 1 | Clock enable before polarity is applied |
| sr | input | 1 | Synchronous set/reset before polarity is applied |
| bx | input | 1 | Lower bypass input |
| by | input | 1 | Upper bypass input |
| cin | input | 1 | Carry entering the bottom of the slice |
| f_in | input | LUT_K | Lower table inputs |
| g_in | input | LUT_K | Upper table inputs |
| lut_f_cfg | input | 2**LUT_K | Lower table contents |
| lut_g_cfg | input | 2**LUT_K | Upper table contents |
| x_sel | input | 2 | X source: 0 table, 1 sum, 2 wide mux, 3 table |
| y_sel | input | 1 | Y source: 0 table, 1 sum |
| dx_sel | input | 1 | Lower flip-flop D: 0 X line, 1 BX |
| dy_sel | input | 1 | Upper flip-flop D: 0 Y line, 1 BY |
| rev_en | input | 1 | Lets effective BY drive REV on both flip-flops |
| ffx_init | input | 1 | Value SR loads into the lower flip-flop |
| ffy_init | input | 1 | Value SR loads into the upper flip-flop |
| inv_clk | input | 1 | Invert clock |
| inv_ce | input | 1 | Invert CE |
| inv_sr | input | 1 | Invert SR |
| inv_bx | input | 1 | Invert BX |
| inv_by | input | 1 | Invert BY |
| x | output | 1 | Lower combinational output |
| y | output | 1 | Upper combinational output |
| xq | output | 1 | Lower registered output |
| yq | output | 1 | Upper registered output |
| bxout | output | 1 | Effective BX passed straight through |
| byout | output | 1 | Effective BY passed straight through |
| cout | output | 1 | Carry leaving the top of the slice |

## Verification
The bench builds the slice with the default `LUT_K` of 4. Each table therefore has sixteen entries, so a one-hot sweep can reach every table index directly, and every valid `x_sel` code can be tried in a short vector list. Carry kill, carry propagate and both inversions of the bypass inputs are covered, each compared against a reference computed in the bench. Directed sequences then step the flip-flops through loading, holding, SR, REV and their conflict, and end with the inverted clock.

// File: rtl/logic_slice.sv
module logic_slice #(
  parameter int LUT_K = 4,
  localparam int LUT_W = 1 << LUT_K
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic             bx,
  input  logic             by,
  input  logic             cin,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic [LUT_W-1:0] lut_f_cfg,
  input  logic [LUT_W-1:0] lut_g_cfg,
  input  logic [1:0]       x_sel,
  input  logic             y_sel,
  input  logic             dx_sel,
  input  logic             dy_sel,
  input  logic             rev_en,
  input  logic             ffx_init,
  input  logic             ffy_init,
  input  logic             inv_clk,
  input  logic             inv_ce,
  input  logic             inv_sr,
  input  logic             inv_bx,
  input  logic             inv_by,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq,
  output logic             bxout,
  output logic             byout,
  output logic             cout
);

  logic clk_e, ce_e, sr_e, bx_e, by_e, rev_e;
  logic f_o, g_o, c_mid, wide_o;

  assign clk_e = clk ^ inv_clk;
  assign ce_e  = ce ^ inv_ce;
  assign sr_e  = sr ^ inv_sr;
  assign bx_e  = bx ^ inv_bx;
  assign by_e  = by ^ inv_by;
  assign rev_e = rev_en & by_e;

  assign f_o = lut_f_cfg[f_in];
  assign g_o = lut_g_cfg[g_in];

  assign c_mid  = f_o ? cin : bx_e;
  assign cout   = g_o ? c_mid : by_e;
  assign wide_o = bx_e ? g_o : f_o;

  always_comb begin
    unique case (x_sel)
      2'd1:    x = f_o ^ cin;
      2'd2:    x = wide_o;
      default: x = f_o;
    endcase
  end

  assign y     = y_sel ? (g_o ^ c_mid) : g_o;
  assign bxout = bx_e;
  assign byout = by_e;

  always_ff @(posedge clk_e) begin
    if (sr_e) begin
      xq <= ffx_init;
      yq <= ffy_init;
    end else if (rev_e) begin
      xq <= ~ffx_init;
      yq <= ~ffy_init;
    end else if (ce_e) begin
      xq <= dx_sel ? bx_e : x;
      yq <= dy_sel ? by_e : y;
    end
  end

endmodule

// File: rtl/logic_slice_chk.sv
module logic_slice_chk (
  input logic clk,
  input logic inv_clk,
  input logic ce,
  input logic inv_ce,
  input logic sr,
  input logic inv_sr,
  input logic bx,
  input logic inv_bx,
  input logic by,
  input logic inv_by,
  input logic rev_en,
  input logic dx_sel,
  input logic ffx_init,
  input logic ffy_init,
  input logic xq,
  input logic yq
);
  logic ck;
  logic armed = 1'b0;
  logic s_e, r_e, c_e;
  assign ck  = clk ^ inv_clk;
  assign s_e = sr ^ inv_sr;
  assign r_e = rev_en & (by ^ inv_by);
  assign c_e = ce ^ inv_ce;

  always_ff @(posedge ck) armed <= 1'b1;

  AST_SR_LOADS_INIT: assert property (@(posedge ck) disable iff (!armed)
    s_e |=> (xq == ffx_init) && (yq == ffy_init)); // R9
  AST_REV_LOADS_INVERSE: assert property (@(posedge ck) disable iff (!armed)
    (!s_e && r_e) |=> (xq == !ffx_init) && (yq == !ffy_init)); // R10
  AST_CE_LOW_HOLDS: assert property (@(posedge ck) disable iff (!armed)
    (!s_e && !r_e && !c_e) |=> $stable(xq) && $stable(yq)); // R8
  AST_BX_TO_XQ: assert property (@(posedge ck) disable iff (!armed)
    (!s_e && !r_e && c_e && dx_sel) |=> xq == $past(bx ^ inv_bx)); // R7
endmodule

bind logic_slice logic_slice_chk u_chk (
  .clk(clk), .inv_clk(inv_clk), .ce(ce), .inv_ce(inv_ce), .sr(sr), .inv_sr(inv_sr),
  .bx(bx), .inv_bx(inv_bx), .by(by), .inv_by(inv_by), .rev_en(rev_en),
  .dx_sel(dx_sel), .ffx_init(ffx_init), .ffy_init(ffy_init), .xq(xq), .yq(yq)
);

// File: tb/logic_slice_tb.sv
module logic_slice_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic ce, sr, bx, by, cin, y_sel, dx_sel, dy_sel, rev_en, ffx_init, ffy_init;
  logic inv_clk, inv_ce, inv_sr, inv_bx, inv_by;
  logic [3:0] f_in, g_in;
  logic [15:0] lut_f_cfg, lut_g_cfg;
  logic [1:0] x_sel;
  logic x, y, xq, yq, bxout, byout, cout;
  int n_chk = 0, n_fail = 0;

  logic_slice u_dut (.*);

  // vector: f_cfg, g_cfg, f_in, g_in, bx, by, cin, x_sel, y_sel, inv_bx, inv_by
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {16'h8000, 16'h6996, 4'hF, 4'h5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'h6996, 4'hE, 4'h7, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {16'h6666, 16'h6666, 4'h1, 4'h3, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 4'h2, 4'h9, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
    {16'h0000, 16'hFFFF, 4'h4, 4'h4, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'h0000, 4'h4, 4'h4, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0},
    {16'hFFFF, 16'hFFFF, 4'hA, 4'hC, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    {16'h00FF, 16'hF0F0, 4'h3, 4'hD, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ce = 0; sr = 0; bx = 0; by = 0; cin = 0; f_in = 0; g_in = 0;
    lut_f_cfg = 0; lut_g_cfg = 0; x_sel = 0; y_sel = 0; dx_sel = 0; dy_sel = 0;
    rev_en = 0; ffx_init = 0; ffy_init = 1;
    inv_clk = 0; inv_ce = 0; inv_sr = 0; inv_bx = 0; inv_by = 0;
    step();

    for (int i = 0; i < NV; i++) begin
      logic fo, go, bxe, bye, cm, ex, ey, eco;
      {lut_f_cfg, lut_g_cfg, f_in, g_in, bx, by, cin, x_sel, y_sel, inv_bx, inv_by} = VEC[i];
      #1;
      bxe = bx ^ inv_bx; bye = by ^ inv_by;
      fo = lut_f_cfg[f_in]; go = lut_g_cfg[g_in];
      cm = fo ? cin : bxe;
      eco = go ? cm : bye;
      ex = (x_sel == 2'd1) ? (fo ^ cin) : (x_sel == 2'd2) ? (bxe ? go : fo) : fo;
      ey = y_sel ? (go ^ cm) : go;
      check("R1/R3/R5 x", x, ex);
      check("R2/R3 y", y, ey);
      check("R4 cout", cout, eco);
      check("R6 bxout", bxout, bxe);
      check("R6 byout", byout, bye);
    end
    inv_bx = 0; inv_by = 0; x_sel = 0; y_sel = 0;

    for (int i = 0; i < 16; i++) begin
      lut_f_cfg = 16'd1 << i; lut_g_cfg = ~(16'd1 << i);
      f_in = 4'(i); g_in = 4'(i); #1;
      check("R1 one-hot hit", x, 1'b1);
      check("R2 one-hot hit", y, 1'b0);
      f_in = 4'(i ^ 1); #1;
      check("R1 one-hot miss", x, 1'b0);
    end

    // flip-flop sequences
    sr = 1; step();
    check("R9 xq init", xq, 1'b0); check("R9 yq init", yq, 1'b1);
    sr = 0; ce = 1; lut_f_cfg = 16'hFFFF; dx_sel = 0; dy_sel = 1; by = 0; step();
    check("R7 xq from X", xq, 1'b1); check("R7 yq from BY", yq, 1'b0);
    ce = 0; lut_f_cfg = 16'h0000; by = 1; step();
    check("R8 xq hold", xq, 1'b1); check("R8 yq hold", yq, 1'b0);
    sr = 1; step();
    check("R9 xq sr with ce low", xq, 1'b0); check("R9 yq sr with ce low", yq, 1'b1);
    sr = 0; rev_en = 1; by = 1; step();
    check("R10 xq rev", xq, 1'b1); check("R10 yq rev", yq, 1'b0);
    sr = 1; step();
    check("R10 sr over rev xq", xq, 1'b0); check("R10 sr over rev yq", yq, 1'b1);
    rev_en = 0; inv_sr = 1; inv_ce = 1; ce = 0; dx_sel = 1; bx = 1;
    dy_sel = 0; lut_g_cfg = 16'h0000; step();
    check("R11 inv ce/sr xq", xq, 1'b1); check("R11 inv ce/sr yq", yq, 1'b0);

    inv_clk = 1; sr = 0;
    @(negedge clk); #1;
    check("R11 negedge sr xq", xq, 1'b0); check("R11 negedge sr yq", yq, 1'b1);
    sr = 1; bx = 1;
    @(posedge clk); #1;
    check("R11 rising edge ignored", xq, 1'b0);
    @(negedge clk); #1;
    check("R11 falling edge loads", xq, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule